// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact processor that retires one instruction per clock from a small fixed-encoding instruction set. Every instruction is one 32-bit word. The core holds a 32 x 32-bit register file, an arithmetic/logic unit, immediate sign extension and program-counter selection. It also contains a word-organised instruction store and a word-organised data store.

A two-state controller gates execution. In `HOLD` the program counter and all architectural state stay frozen. In `EXEC` one instruction retires at every rising edge. The transition HOLD->EXEC is taken at the edge where `run` is high, and EXEC->HOLD at the edge where `run` is low. Both stores are filled through a word-wide load port, which works in either state. Any register can be read back combinationally through a debug port.

The supported operations are add, subtract, and, or, nor, the two logical shifts, signed set-less-than, add-immediate, word load and store, the two conditional branches, the absolute jump and the jump through a register. Every other encoding advances the PC and does nothing else.

Top module: `scpu_core`

## Requirements
- R1: While `rst_n` is low, the PC is cleared to 0, all registers are cleared to 0 and the controller enters HOLD.
- R2: Instructions retire only at edges where the controller is in EXEC, one per edge. HOLD->EXEC takes the first edge with `run` high, and an edge with `run` low returns to HOLD after retiring. Holding `run` high across N edges therefore retires exactly N instructions. In HOLD the PC does not change and no register is written.
- R3: At an edge with `ld_we` high, `ld_data` is written at word index `ld_addr`. It goes to the instruction store when `ld_sel`=0 and to the data store when `ld_sel`=1.
- R4: R-type words have opcode[31:26]=0, rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. funct 32 writes rs+rt to rd and funct 34 writes rs-rt to rd, both modulo 2^32.
- R5: funct 36 writes rs AND rt to rd, funct 37 writes rs OR rt, and funct 39 writes NOT(rs OR rt).
- R6: funct 0 shifts rt left by shamt and funct 2 shifts rt right by shamt. Both fill the vacated bits with zeros, and the result goes to rd.
- R7: funct 42 writes 1 to rd when rs < rt as two's-complement values, and 0 otherwise.
- R8: Opcode 8 writes rs plus the bit-15 sign-extended immediate[15:0] to rt.
- R9: Opcode 35 loads the data word at byte address rs+sext(imm) into rt. Opcode 43 stores rt there. The word index is address bits [n:2].
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4+4*sext(imm). An untaken branch goes to PC+4.
- R12: Opcode 2 sets the PC to {(PC+4)[31:28], addr[25:0], 2'b00}. R-type funct 8 sets the PC to rs.
- R13: An unrecognised opcode, or an unrecognised funct under opcode 0, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execution request for the controller |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction store, 1 data store |
| ld_addr | input | 6 | Load word index |
| ld_data | input | 32 | Load word |
| dbg_reg | input | 5 | Register number to read back |
| dbg_data | output | 32 | Value of register `dbg_reg` (combinational) |
| pc_o | output | 32 | Current program counter |

## Verification
With `run` raised before edge k, edge k only moves the controller into EXEC. Instructions then retire at edges k+1 onward, and the PC and the written register change at the edge that retires the instruction. The directed tests hold `run` high for exactly N edges, wait one further falling edge, and only then sample `pc_o` and `dbg_data`, so each read sees the state after exactly N retirements. Single-step runs are used around branches and jumps, so the PC is compared after every control transfer. Register values are read at a falling edge, half a period away from any update.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JMP   = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_NOR = 6'd39;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL, ALU_SLT
    } alu_op_e;

    typedef enum logic {
        ST_HOLD,
        ST_EXEC
    } core_state_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    src_imm;
        logic    mem_rd;
        logic    mem_wr;
        logic    br_eq;
        logic    br_ne;
        logic    jmp;
        logic    jreg;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra1,
    input  logic [IW-1:0] ra2,
    input  logic [IW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // register zero is wired to zero on every read path
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W    = 32,
    localparam int SHW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLL: y = b << shamt;
            ALU_SRL: y = b >> shamt;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/scpu_decode.sv
module scpu_decode
    import scpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                unique case (funct)
                    FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
                    FN_NOR: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_NOR; end
                    FN_SLL: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SLL; end
                    FN_SRL: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SRL; end
                    FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
                    FN_JR:  ctrl.jreg = 1'b1;
                    default: ;
                endcase
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1; end
            OP_LW:   begin ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1; ctrl.mem_rd = 1'b1; end
            OP_SW:   begin ctrl.src_imm = 1'b1; ctrl.mem_wr = 1'b1; end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            OP_JMP:  ctrl.jmp   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/scpu_core.sv
module scpu_core
    import scpu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREG       = 32,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW,
    localparam int RAW = $clog2(NREG),
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            ld_we,
    input  logic            ld_sel,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [RAW-1:0]  dbg_reg,
    output logic [XLEN-1:0] dbg_data,
    output logic [XLEN-1:0] pc_o
);

    // ---------------- controller ----------------
    core_state_e state, state_nx;
    logic        exec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_HOLD: state_nx = run ? ST_EXEC : ST_HOLD;
            ST_EXEC: state_nx = run ? ST_EXEC : ST_HOLD;
            default: state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_EXEC: exec = 1'b1;
            default: exec = 1'b0;
        endcase
    end

    // ---------------- stores ----------------
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    logic [XLEN-1:0] pc, pc4, pc_nx;
    logic [XLEN-1:0] instr;

    assign instr = imem[pc[IAW+1:2]];

    // ---------------- decode ----------------
    ctrl_t ctrl;
    logic [RAW-1:0] f_rs, f_rt, f_rd, wa;
    logic [XLEN-1:0] simm, rs_val, rt_val, alu_b, alu_y, wb;
    logic [DAW-1:0]  didx;
    logic            rf_we, take_br;

    assign f_rs = instr[25:21];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];
    assign simm = {{(XLEN-16){instr[15]}}, instr[15:0]};

    scpu_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    scpu_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (wa),
        .wd    (wb),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .ra3   (dbg_reg),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (dbg_data)
    );

    assign alu_b = ctrl.src_imm ? simm : rt_val;

    scpu_alu #(.W(XLEN)) u_alu (
        .op    (ctrl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (instr[SHW+5:6]),
        .y     (alu_y)
    );

    assign didx  = alu_y[DAW+1:2];
    assign wb    = ctrl.mem_rd ? dmem[didx] : alu_y;
    assign wa    = ctrl.dst_rd ? f_rd : f_rt;
    assign rf_we = exec & ctrl.reg_we;

    always_ff @(posedge clk) begin
        if (ld_we && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_we && ld_sel)            dmem[ld_addr[DAW-1:0]] <= ld_data;
        else if (exec && ctrl.mem_wr)   dmem[didx] <= rt_val;
    end

    // ---------------- next PC ----------------
    assign pc4     = pc + XLEN'(4);
    assign take_br = (ctrl.br_eq && (rs_val == rt_val)) ||
                     (ctrl.br_ne && (rs_val != rt_val));

    always_comb begin
        if (ctrl.jreg)     pc_nx = rs_val;
        else if (ctrl.jmp) pc_nx = {pc4[XLEN-1:28], instr[25:0], 2'b00};
        else if (take_br)  pc_nx = pc4 + (simm << 2);
        else               pc_nx = pc4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pc <= '0;
        else if (exec) pc <= pc_nx;
    end

    assign pc_o = pc;

    logic unused_bits;
    assign unused_bits = ^{pc[1:0], pc[XLEN-1:IAW+2], alu_y[1:0], alu_y[XLEN-1:DAW+2],
                           instr[10:SHW+6]};

endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk
    import scpu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec,
    input ctrl_t           ctrl,
    input logic            rf_we,
    input logic [RAW-1:0]  dbg_reg,
    input logic [XLEN-1:0] dbg_data,
    input logic [XLEN-1:0] pc_o
);

    // R1 / R12: PC stays word aligned from reset onward
    a_r1_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);

    // R2: PC frozen while the controller holds
    a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> pc_o == $past(pc_o));

    // R2: no register write outside EXEC
    a_r2_hold_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |-> !rf_we);

    // R13: non-control instructions advance PC by exactly four
    a_r13_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !(ctrl.br_eq || ctrl.br_ne || ctrl.jmp || ctrl.jreg))
        |=> pc_o == $past(pc_o) + XLEN'(4));

    // R10: register zero reads zero on the debug path
    a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_reg == '0) |-> (dbg_data == '0));

endmodule

bind scpu_core scpu_core_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec     (exec),
    .ctrl     (ctrl),
    .rf_we    (rf_we),
    .dbg_reg  (dbg_reg),
    .dbg_data (dbg_data),
    .pc_o     (pc_o)
);

// File: tb/sim_scpu_core.sv
module sim_scpu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_sel = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_reg = '0;
    logic [31:0] dbg_data;
    logic [31:0] pc_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    scpu_core u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .ld_we(ld_we), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_reg(dbg_reg),
        .dbg_data(dbg_data), .pc_o(pc_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int op, int a);
        return {6'(op), 26'(a)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; ld_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(bit sel, int idx, logic [31:0] w);
        ld_we = 1'b1; ld_sel = sel; ld_addr = 6'(idx); ld_data = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic step(int n);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic rreg(int r, output logic [31:0] v);
        dbg_reg = 5'(r);
        #1;
        v = dbg_data;
    endtask

    task automatic t_reset_hold();
        logic [31:0] v;
        do_reset();
        chk("R1 pc after reset", pc_o, 32'd0);
        rreg(31, v); chk("R1 r31 after reset", v, 32'd0);
        load(0, 0, enc_i(8, 0, 1, 9));
        repeat (10) @(negedge clk);
        chk("R2 pc frozen in hold", pc_o, 32'd0);
        rreg(1, v); chk("R2 no write in hold", v, 32'd0);
    endtask

    task automatic t_alu();
        logic [31:0] v;
        do_reset();
        load(0, 0,  enc_i(8, 0, 1, 7));
        load(0, 1,  enc_i(8, 0, 2, -3));
        load(0, 2,  enc_r(1, 2, 3, 0, 32));
        load(0, 3,  enc_r(2, 1, 4, 0, 34));
        load(0, 4,  enc_r(1, 2, 6, 0, 36));
        load(0, 5,  enc_r(1, 2, 7, 0, 37));
        load(0, 6,  enc_r(1, 0, 8, 0, 39));
        load(0, 7,  enc_r(2, 1, 9, 0, 42));
        load(0, 8,  enc_r(1, 2, 10, 0, 42));
        load(0, 9,  enc_r(0, 1, 11, 4, 0));
        load(0, 10, enc_r(0, 2, 12, 28, 2));
        load(0, 11, enc_i(8, 0, 0, 5));
        load(0, 12, enc_r(0, 0, 13, 0, 32));
        load(0, 13, enc_r(0, 1, 0, 0, 32));
        step(14);
        chk("R2 pc after 14 retirements", pc_o, 32'd56);
        rreg(2, v);  chk("R8 addi negative", v, 32'hFFFF_FFFD);
        rreg(3, v);  chk("R4 add", v, 32'd4);
        rreg(4, v);  chk("R4 sub", v, 32'hFFFF_FFF6);
        rreg(6, v);  chk("R5 and", v, 32'd5);
        rreg(7, v);  chk("R5 or", v, 32'hFFFF_FFFF);
        rreg(8, v);  chk("R5 nor", v, 32'hFFFF_FFF8);
        rreg(9, v);  chk("R7 slt signed true", v, 32'd1);
        rreg(10, v); chk("R7 slt signed false", v, 32'd0);
        rreg(11, v); chk("R6 sll", v, 32'h70);
        rreg(12, v); chk("R6 srl zero fill", v, 32'hF);
        rreg(13, v); chk("R10 r0 write discarded", v, 32'd0);
        rreg(0, v);  chk("R10 r0 reads zero", v, 32'd0);
    endtask

    task automatic t_mem();
        logic [31:0] v;
        do_reset();
        load(1, 3, 32'hCAFE_F00D); // R3 data store preload
        load(0, 0, enc_i(8, 0, 1, 16));
        load(0, 1, enc_i(35, 1, 2, -4));
        load(0, 2, enc_i(43, 1, 2, 8));
        load(0, 3, enc_i(35, 0, 3, 24));
        step(4);
        rreg(2, v); chk("R9 lw negative offset / R3 preload", v, 32'hCAFE_F00D);
        rreg(3, v); chk("R9 sw then lw", v, 32'hCAFE_F00D);
    endtask

    task automatic t_branch();
        logic [31:0] v;
        do_reset();
        load(0, 0, enc_i(8, 0, 1, 1));
        load(0, 1, enc_i(4, 1, 0, 5));
        load(0, 2, enc_i(5, 1, 0, 2));
        load(0, 3, enc_i(8, 0, 2, 99));
        load(0, 4, enc_i(8, 0, 2, 98));
        load(0, 5, enc_i(8, 0, 3, 5));
        load(0, 6, enc_i(4, 0, 0, -4));
        step(2);
        chk("R11 beq not taken", pc_o, 32'd8);
        step(1);
        chk("R11 bne taken", pc_o, 32'd20);
        step(2);
        chk("R11 beq taken backward", pc_o, 32'd12);
        rreg(3, v); chk("R11 target executed", v, 32'd5);
        step(1);
        rreg(2, v); chk("R11 fall into skipped word", v, 32'd99);
        chk("R11 pc after", pc_o, 32'd16);
    endtask

    task automatic t_jump();
        logic [31:0] v;
        do_reset();
        load(0, 0,  enc_i(8, 0, 1, 64));
        load(0, 1,  enc_j(2, 16));
        load(0, 16, enc_i(8, 0, 2, 36));
        load(0, 17, enc_r(2, 0, 0, 0, 8));
        load(0, 9,  enc_i(8, 0, 4, 77));
        step(2);
        chk("R12 j absolute", pc_o, 32'd64);
        step(2);
        chk("R12 jr", pc_o, 32'd36);
        step(1);
        rreg(4, v); chk("R12 jr target executed", v, 32'd77);
    endtask

    task automatic t_nop();
        logic [31:0] v;
        do_reset();
        load(0, 0, enc_i(8, 0, 5, 11));
        load(0, 1, 32'hFC25_FFFF);              // opcode 63
        load(0, 2, enc_r(1, 2, 5, 0, 1));       // funct 1
        step(2);
        chk("R13 bad opcode pc+4", pc_o, 32'd8);
        rreg(5, v); chk("R13 bad opcode no write", v, 32'd11);
        step(1);
        chk("R13 bad funct pc+4", pc_o, 32'd12);
        rreg(5, v); chk("R13 bad funct no write", v, 32'd11);
    endtask

    initial begin
        t_reset_hold();
        t_alu();
        t_mem();
        t_branch();
        t_jump();
        t_nop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule